// File: doc/BRIEF.md
# Missing Clock Detector with Reference Failover

This block watches a primary clock against a reference clock that never stops. It declares the primary missing when the primary stops or runs too slowly. A small counter runs on the primary clock. Each time that counter wraps, it restarts a wider counter that runs on the reference clock. If the reference counter reaches its all-ones value without a restart, the primary has gone quiet for too long, and a missing-clock condition is latched.

Once the condition is latched, the block:
- holds a sticky status bit;
- raises a registered clock-fail line, which the chip uses for fault trips and a non-maskable interrupt;
- freezes the detector;
- steers the output clock to the reference, whatever the normal source select says;
- forces the multiplier bypass;
- drives the multiplier setting to zero.

A write-one clear strobe drops the status and restarts both counters, so monitoring re-arms. A disable input suspends the check. After reset the check is enabled.

Top module: `clkmon_failover`

## Requirements
- R1: After reset, `miss_sts` and `clk_fail` are 0.
- R2: With the primary running at the reference rate, no missing-clock condition is raised.
- R3: With the primary running 32 times slower than the reference, no missing-clock condition is raised.
- R4: With the primary 64 or more times slower than the reference, or stopped, `miss_sts` sets. When the primary stops, it sets within 8192 reference cycles plus the synchronizer latency (at most 8200 cycles).
- R5: `clk_fail` rises one reference cycle after `miss_sts` rises.
- R6: Once set, `miss_sts` stays set even if the primary clock resumes. The detector counter is frozen.
- R7: While `miss_sts` is 1:
  - `clk_out` follows `clk_ref` whatever the value of `src_sel`;
  - `pll_bypass` is 1;
  - `mult_out` is 0.
- R8: A one-cycle `clr_wr` pulse, synchronous to `clk_ref`, clears `miss_sts` and `clk_fail` within 4 reference cycles and restarts both counters. If the primary is still absent afterwards, detection fires again.
- R9: While `mon_disable` is 1, no detection occurs. After `mon_disable` returns to 0, a stopped primary is detected within 8200 cycles.
- R10: While `miss_sts` is 0:
  - `clk_out` is `clk_pri` when `src_sel`=0 and `clk_ref` when `src_sel`=1;
  - `pll_bypass` equals `bypass_in`;
  - `mult_out` equals `mult_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary clock under watch |
| clk_ref | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_disable | input | 1 | 1 suspends detection (reference domain) |
| clr_wr | input | 1 | Write-one clear strobe, one `clk_ref` cycle |
| src_sel | input | 1 | Normal source select: 0 primary, 1 reference |
| bypass_in | input | 1 | Normal multiplier bypass request |
| mult_in | input | MULT_W | Normal multiplier setting |
| miss_sts | output | 1 | Sticky missing-clock status |
| clk_fail | output | 1 | Registered clock-fail indication |
| clk_out | output | 1 | Selected output clock |
| pll_bypass | output | 1 | Multiplier bypass, forced on failure |
| mult_out | output | MULT_W | Multiplier setting, zeroed on failure |

## Verification
The assertions take three things for granted:
- `clr_wr` and `mon_disable` change only in step with `clk_ref`.
- `clr_wr` is a single-cycle pulse.
- The primary-wrap toggle changes at most once per synchronizer window, which holds because the primary counter needs many primary cycles to wrap.

The stimulus drives every control input on the falling edge of the reference clock. For the 64x case, it starts the primary one nanosecond after a reference edge, so the synchronizer latency stays constant and the restart spacing is exact. Clock speeds change only while the status is clear, and a clear strobe follows each change.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

   localparam int unsigned CLKMON_PRI_W_DEF  = 7;
   localparam int unsigned CLKMON_REF_W_DEF  = 13;
   localparam int unsigned CLKMON_SYNC_DEF   = 2;
   localparam int unsigned CLKMON_MULT_W_DEF = 7;

   // slowdown ratio at which the reference counter first overflows
   function automatic int unsigned clkmon_trip_ratio(input int unsigned pri_w,
                                                     input int unsigned ref_w);
      return (1 << ref_w) / (1 << pri_w);
   endfunction

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkmon_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];

endmodule

// File: rtl/clkmon_pri_cnt.sv
module clkmon_pri_cnt #(
   parameter int unsigned PRI_W  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic clk_pri,
   input  logic rst_n,
   input  logic clr_tgl_ref,   // clear toggle from the reference domain
   output logic wrap_tgl       // flips on every wrap of the primary counter
);

   localparam logic [PRI_W-1:0] FULL = {PRI_W{1'b1}};

   generate
      if (PRI_W < 2) begin : g_bad_width
         $error("clkmon_pri_cnt: PRI_W must be at least 2");
      end
   endgenerate

   logic             clr_s, clr_d, clr_evt;
   logic [PRI_W-1:0] cnt;

   clkmon_sync #(.STAGES(STAGES)) u_clr_sync (
      .clk (clk_pri), .rst_n (rst_n), .d (clr_tgl_ref), .q (clr_s)
   );

   always_ff @(posedge clk_pri or negedge rst_n) begin
      if (!rst_n) clr_d <= 1'b0;
      else        clr_d <= clr_s;
   end

   assign clr_evt = clr_s ^ clr_d;

   always_ff @(posedge clk_pri or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         wrap_tgl <= 1'b0;
      end else if (clr_evt) begin
         cnt      <= '0;
      end else begin
         cnt <= cnt + 1'b1;
         if (cnt == FULL) wrap_tgl <= ~wrap_tgl;
      end
   end

   // toggle flips only when the counter was full and no clear was pending (R2)
   assert_wrap_at_full_R2: assert property (@(posedge clk_pri) disable iff (!rst_n)
      (cnt == FULL && !clr_evt) |=> (wrap_tgl != $past(wrap_tgl)));
   assert_no_wrap_early_R2: assert property (@(posedge clk_pri) disable iff (!rst_n)
      (cnt != FULL) |=> (wrap_tgl == $past(wrap_tgl)));

endmodule

// File: rtl/clkmon_ref_det.sv
module clkmon_ref_det #(
   parameter int unsigned REF_W  = 13,
   parameter int unsigned STAGES = 2
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic wrap_tgl_pri,
   input  logic mon_disable,
   input  logic clr_wr,
   output logic sts,
   output logic fail,
   output logic clr_tgl
);

   localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};
   localparam logic [REF_W-1:0] ONE  = {{(REF_W-1){1'b0}}, 1'b1};

   logic             wrap_s, wrap_d, restart;
   logic             clr_q;
   logic             hit;
   logic [REF_W-1:0] cnt;

   clkmon_sync #(.STAGES(STAGES)) u_wrap_sync (
      .clk (clk_ref), .rst_n (rst_n), .d (wrap_tgl_pri), .q (wrap_s)
   );

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         wrap_d  <= 1'b0;
         clr_q   <= 1'b0;
         clr_tgl <= 1'b0;
      end else begin
         wrap_d  <= wrap_s;
         clr_q   <= clr_wr;
         clr_tgl <= clr_tgl ^ clr_wr;
      end
   end

   assign restart = wrap_s ^ wrap_d;
   assign hit     = !sts && !mon_disable && !clr_q && !restart && (cnt == FULL);

   // a restart loads one so the restart cycle itself counts toward the window
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr_q)            cnt <= '0;
      else if (sts)              cnt <= cnt;
      else if (mon_disable)      cnt <= '0;
      else if (restart)          cnt <= ONE;
      else if (cnt != FULL)      cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         sts  <= 1'b0;
         fail <= 1'b0;
      end else begin
         if (clr_q)    sts <= 1'b0;
         else if (hit) sts <= 1'b1;
         fail <= sts && !clr_q;
      end
   end

   assert_rise_on_full_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(sts) |-> ($past(cnt) == FULL));
   assert_fail_lags_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(sts) |=> fail);
   assert_frozen_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (sts && !clr_q) |=> ($stable(cnt) && sts));
   assert_clear_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      clr_q |=> (!sts && cnt == '0));
   assert_disabled_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      mon_disable |=> !$rose(sts));

endmodule

// File: rtl/clkmon_sel.sv
module clkmon_sel #(
   parameter int unsigned MULT_W = 7
) (
   input  logic              force_ref,
   input  logic              clk_pri,
   input  logic              clk_ref,
   input  logic              src_sel,
   input  logic              bypass_in,
   input  logic [MULT_W-1:0] mult_in,
   output logic              clk_out,
   output logic              pll_bypass,
   output logic [MULT_W-1:0] mult_out
);

   generate
      if (MULT_W < 1) begin : g_bad_mult
         $error("clkmon_sel: MULT_W must be at least 1");
      end
   endgenerate

   logic use_ref;

   always_comb begin
      use_ref    = force_ref | src_sel;
      clk_out    = use_ref ? clk_ref : clk_pri;
      pll_bypass = force_ref | bypass_in;
      mult_out   = force_ref ? '0 : mult_in;
   end

endmodule

// File: rtl/clkmon_failover.sv
module clkmon_failover
   import clkmon_pkg::*;
#(
   parameter int unsigned PRI_W  = CLKMON_PRI_W_DEF,
   parameter int unsigned REF_W  = CLKMON_REF_W_DEF,
   parameter int unsigned SYNC   = CLKMON_SYNC_DEF,
   parameter int unsigned MULT_W = CLKMON_MULT_W_DEF
) (
   input  logic              clk_pri,
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              mon_disable,
   input  logic              clr_wr,
   input  logic              src_sel,
   input  logic              bypass_in,
   input  logic [MULT_W-1:0] mult_in,
   output logic              miss_sts,
   output logic              clk_fail,
   output logic              clk_out,
   output logic              pll_bypass,
   output logic [MULT_W-1:0] mult_out
);

   localparam int unsigned TRIP_RATIO = clkmon_trip_ratio(PRI_W, REF_W);

   generate
      if (REF_W <= PRI_W + 1) begin : g_bad_ratio
         $error("clkmon_failover: REF_W must exceed PRI_W by at least 2");
      end
      if (TRIP_RATIO < 2) begin : g_bad_trip
         $error("clkmon_failover: trip ratio too small");
      end
   endgenerate

   logic wrap_tgl, clr_tgl;

   clkmon_pri_cnt #(.PRI_W(PRI_W), .STAGES(SYNC)) u_pri (
      .clk_pri     (clk_pri),
      .rst_n       (rst_n),
      .clr_tgl_ref (clr_tgl),
      .wrap_tgl    (wrap_tgl)
   );

   clkmon_ref_det #(.REF_W(REF_W), .STAGES(SYNC)) u_det (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .wrap_tgl_pri (wrap_tgl),
      .mon_disable  (mon_disable),
      .clr_wr       (clr_wr),
      .sts          (miss_sts),
      .fail         (clk_fail),
      .clr_tgl      (clr_tgl)
   );

   clkmon_sel #(.MULT_W(MULT_W)) u_sel (
      .force_ref  (miss_sts),
      .clk_pri    (clk_pri),
      .clk_ref    (clk_ref),
      .src_sel    (src_sel),
      .bypass_in  (bypass_in),
      .mult_in    (mult_in),
      .clk_out    (clk_out),
      .pll_bypass (pll_bypass),
      .mult_out   (mult_out)
   );

   assert_forced_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      miss_sts |-> (pll_bypass && mult_out == '0));
   assert_pass_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !miss_sts |-> (mult_out == mult_in && pll_bypass == bypass_in));

endmodule

// File: tb/sim_clkmon_failover.sv
`timescale 1ns/1ps
module sim_clkmon_failover;

   localparam int MULT_W = 7;

   logic clk_ref = 1'b0;
   logic clk_pri = 1'b0;
   logic rst_n = 1'b0;
   logic mon_disable = 1'b0;
   logic clr_wr = 1'b0;
   logic src_sel = 1'b0;
   logic bypass_in = 1'b0;
   logic [MULT_W-1:0] mult_in = 7'd25;
   logic miss_sts, clk_fail, clk_out, pll_bypass;
   logic [MULT_W-1:0] mult_out;

   bit  pri_run = 1'b0;
   real pri_half = 2.0;
   int  n_chk = 0;
   int  n_err = 0;

   always #2 clk_ref = ~clk_ref;

   always begin
      if (pri_run) #(pri_half) clk_pri = ~clk_pri;
      else #1;
   end

   clkmon_failover u0 (
      .clk_pri (clk_pri), .clk_ref (clk_ref), .rst_n (rst_n),
      .mon_disable (mon_disable), .clr_wr (clr_wr), .src_sel (src_sel),
      .bypass_in (bypass_in), .mult_in (mult_in), .miss_sts (miss_sts),
      .clk_fail (clk_fail), .clk_out (clk_out), .pll_bypass (pll_bypass),
      .mult_out (mult_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_ref);
   endtask

   task automatic stop_pri(input logic lvl);
      pri_run = 1'b0;
      #300;
      clk_pri = lvl;
      @(negedge clk_ref);
   endtask

   task automatic run_pri(input real half);
      pri_run = 1'b0;
      #300;
      @(posedge clk_ref);
      #1;
      pri_half = half;
      pri_run  = 1'b1;
      @(negedge clk_ref);
   endtask

   task automatic do_clear();
      @(negedge clk_ref);
      clr_wr = 1'b1;
      @(negedge clk_ref);
      clr_wr = 1'b0;
      cyc(4);
   endtask

   task automatic wait_detect(input int limit, output int n);
      n = 0;
      while (!miss_sts && n < limit) begin
         @(negedge clk_ref);
         n++;
      end
   endtask

   task automatic t_reset();
      clk_pri = 1'b1;
      rst_n = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(3);
      chk(miss_sts == 1'b0, "R1", "miss_sts after reset", miss_sts, 0);
      chk(clk_fail == 1'b0, "R1", "clk_fail after reset", clk_fail, 0);
      src_sel = 1'b0;
      #0.5;
      chk(clk_out == 1'b1, "R10", "clk_out selects primary", clk_out, 1);
      src_sel = 1'b1;
      #0.5;
      chk(clk_out == 1'b0, "R10", "clk_out selects reference", clk_out, 0);
      src_sel = 1'b0;
      chk(mult_out == mult_in, "R10", "mult_out passthrough", mult_out, mult_in);
      chk(pll_bypass == 1'b0, "R10", "pll_bypass passthrough", pll_bypass, 0);
      do_clear();
   endtask

   task automatic t_same_rate();
      run_pri(2.0);
      do_clear();
      cyc(20000);
      chk(miss_sts == 1'b0, "R2", "no detect at 1x", miss_sts, 0);
   endtask

   task automatic t_slow32();
      run_pri(64.0);
      do_clear();
      cyc(20000);
      chk(miss_sts == 1'b0, "R3", "no detect at 32x slow", miss_sts, 0);
   endtask

   task automatic t_slow64();
      int n;
      run_pri(128.0);
      do_clear();
      wait_detect(20000, n);
      chk(miss_sts == 1'b1, "R4", "detect at 64x slow", miss_sts, 1);
      run_pri(2.0);
      do_clear();
      chk(miss_sts == 1'b0, "R8", "clear after 64x detect", miss_sts, 0);
      chk(clk_fail == 1'b0, "R8", "clk_fail cleared", clk_fail, 0);
      cyc(10000);
      chk(miss_sts == 1'b0, "R8", "stays clear with primary back", miss_sts, 0);
   endtask

   task automatic t_stopped();
      int n;
      stop_pri(1'b0);
      chk(miss_sts == 1'b0, "R4", "not yet set at stop", miss_sts, 0);
      wait_detect(8200, n);
      chk(miss_sts == 1'b1, "R4", "detect within 8200 cycles", n, 8200);
      chk(clk_fail == 1'b0, "R5", "clk_fail lags by one cycle", clk_fail, 0);
      cyc(1);
      chk(clk_fail == 1'b1, "R5", "clk_fail high next cycle", clk_fail, 1);
      src_sel = 1'b0;
      bypass_in = 1'b0;
      mult_in = 7'd25;
      #0.5;
      chk(clk_out == clk_ref, "R7", "clk_out = ref (low phase)", clk_out, clk_ref);
      @(posedge clk_ref);
      #1;
      chk(clk_out == 1'b1, "R7", "clk_out = ref (high phase)", clk_out, 1);
      chk(pll_bypass == 1'b1, "R7", "bypass forced", pll_bypass, 1);
      chk(mult_out == '0, "R7", "multiplier zeroed", mult_out, 0);
      run_pri(2.0);
      cyc(2000);
      chk(miss_sts == 1'b1, "R6", "sticky after primary resumes", miss_sts, 1);
      chk(clk_fail == 1'b1, "R6", "clk_fail stays high", clk_fail, 1);
      stop_pri(1'b0);
      do_clear();
      chk(miss_sts == 1'b0, "R8", "clear with primary stopped", miss_sts, 0);
      wait_detect(8200, n);
      chk(miss_sts == 1'b1, "R8", "re-armed detection fires", n, 8200);
      run_pri(2.0);
      do_clear();
   endtask

   task automatic t_disable();
      int n;
      @(negedge clk_ref);
      mon_disable = 1'b1;
      stop_pri(1'b0);
      cyc(9000);
      chk(miss_sts == 1'b0, "R9", "no detect while disabled", miss_sts, 0);
      mon_disable = 1'b0;
      wait_detect(8200, n);
      chk(miss_sts == 1'b1, "R9", "detect after re-enable", n, 8200);
      run_pri(2.0);
      do_clear();
      chk(miss_sts == 1'b0, "R8", "final clear", miss_sts, 0);
   endtask

   initial begin
      #700000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_same_rate();
      t_slow32();
      t_slow64();
      t_stopped();
      t_disable();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule